// File: doc/BRIEF.md
# Polyphase Horizontal Line Resampler

This block stretches or shrinks one video line along the horizontal axis. Input pixels arrive on a ready/valid stream. Output pixels leave on a second ready/valid stream. A fixed-point position accumulator tracks where each output pixel falls in the input line. Before each output, the accumulator decides how many fresh input pixels to shift into a five-entry window. That number is zero when an input pixel is reused (upscaling), one at unity ratio, and several when input pixels are skipped (downscaling). The fractional part of the position picks one of eight coefficient sets, and a five-tap filter over the window produces the output pixel.

A line begins with a one-cycle `line_start` pulse. The step size, the two starting positions (one per field), the input and output line lengths and the coefficient bank are static configuration inputs for the whole line. A `line_start` pulse that arrives in the middle of a line throws the line away and begins a new one. After the last output of a line, the block waits for the next pulse.

Top module: `hresamp`

## Requirements
- R1: After reset, and until the first `line_start`, `out_valid` and `in_ready` both stay low, even while `in_valid` is high.
- R2: The first input pixel of a line is copied into the centre tap and every tap left of it. The next two input pixels fill the two right-hand taps. The first output is therefore centred on input pixel 0.
- R3: On `line_start` the position accumulator loads `init_odd` when `field_sel` is 1 and `init_even` when it is 0.
- R4: After output k is accepted, the window shifts left by s = ((acc+512+inc)>>10) − ((acc+512)>>10) new pixels, and then acc becomes acc+inc. The shift s may be 0, in which case the same window is reused. When s is greater than 1, input pixels are skipped.
- R5: The phase is acc[9:7]. Coefficient c(p,t) for phase p and tap t is the signed 8-bit field `coef[(p*5+t)*8 +: 8]`. Tap 0 is the oldest (leftmost) pixel and tap 4 the newest.
- R6: An output pixel is Σ c(p,t)·pixel(t), plus 64, arithmetically shifted right by 7, then clamped to the range 0 to 255.
- R7: Once `in_len` pixels have been taken, every further shift repeats the last input pixel and `in_ready` stays low. A line takes exactly min(`in_len`, last centre index + 3) input pixels.
- R8: Exactly `out_len` outputs are produced. `out_last` is high only with the final one. After that output is accepted, the block idles with `in_ready` and `out_valid` low.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_pix` hold steady. No input is taken while an output is pending.
- R10: A `line_start` pulse in any state abandons the current line and restarts it, following R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that starts (or restarts) a line |
| field_sel | input | 1 | Selects which starting position is used |
| inc | input | INC_W | Position step per output, 10 fractional bits |
| init_even | input | ACC_W | Starting position when field_sel is 0 |
| init_odd | input | ACC_W | Starting position when field_sel is 1 |
| in_len | input | LEN_W | Number of input pixels in the line (at least 1) |
| out_len | input | LEN_W | Number of output pixels to produce (at least 1) |
| coef | input | TAPS*8*COEF_W | Coefficient bank, packed as in R5 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel |
| in_pix | input | PIX_W | Input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_pix | output | PIX_W | Filtered output pixel |
| out_last | output | 1 | Marks the final output of the line |

## Verification
- **First output:** the first `out_valid` rises three edges after the last priming pixel is taken. These three edges are the empty-load check, the coefficient capture and the filter register.
- **Later outputs:** after an output is accepted, the next one is due no earlier than s+3 edges later. Each of the s shifts also waits for its input handshake.
- **Idle after the line:** `in_ready` and `out_valid` fall at the edge that accepts the final output.

Since the latency depends on the stall pattern, the bench does not wait for fixed delays. It drives its inputs at the falling edge, lets them settle for half a nanosecond, and then records every handshake that the next rising edge will complete. Each accepted output is compared in order against the queue built by its behavioural model. The stall hold and the idle state after the line are checked on the very next sample.

// File: rtl/hresamp.sv
module hresamp #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 5,
  parameter int PH_W   = 3,
  parameter int FRAC_W = 10,
  parameter int ACC_W  = 24,
  parameter int INC_W  = 16,
  parameter int LEN_W  = 12
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               line_start,
  input  logic                               field_sel,
  input  logic [INC_W-1:0]                   inc,
  input  logic [ACC_W-1:0]                   init_even,
  input  logic [ACC_W-1:0]                   init_odd,
  input  logic [LEN_W-1:0]                   in_len,
  input  logic [LEN_W-1:0]                   out_len,
  input  logic [TAPS*(1<<PH_W)*COEF_W-1:0]   coef,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [PIX_W-1:0]                   in_pix,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [PIX_W-1:0]                   out_pix,
  output logic                               out_last
);
  localparam int CTR    = TAPS / 2;
  localparam int PRIME  = TAPS - 1 - CTR;
  localparam int STEP_W = ACC_W - FRAC_W;
  localparam int CSH    = COEF_W - 1;
  localparam int SUM_W  = PIX_W + COEF_W + $clog2(TAPS) + 1;
  localparam logic [ACC_W-1:0]        HALF = ACC_W'(1) << (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] RND  = SUM_W'(1) << (CSH - 1);
  localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << PIX_W) - 1);

  typedef enum logic [2:0] {S_WAIT, S_INIT, S_LOAD, S_PHASE, S_FIR, S_OUT} st_t;

  st_t                       state;
  logic [ACC_W-1:0]          acc;
  logic [LEN_W-1:0]          in_cnt, out_cnt;
  logic [STEP_W-1:0]         left;
  logic [PIX_W-1:0]          taps [TAPS];
  logic signed [COEF_W-1:0]  cq   [TAPS];

  logic [ACC_W-1:0]          acc_h, acc_n;
  logic [STEP_W-1:0]         step;
  logic [PH_W-1:0]           ph;
  logic                      have_in, do_shift;
  logic [PIX_W-1:0]          new_pix;
  logic signed [SUM_W-1:0]   sum, rnd;
  logic [PIX_W-1:0]          sat;

  assign acc_h    = acc + HALF;
  assign acc_n    = acc_h + ACC_W'(inc);
  assign step     = acc_n[ACC_W-1:FRAC_W] - acc_h[ACC_W-1:FRAC_W];
  assign ph       = acc[FRAC_W-1 -: PH_W];
  assign have_in  = in_cnt < in_len;
  assign new_pix  = have_in ? in_pix : taps[TAPS-1];
  assign do_shift = (state == S_LOAD) && (left != '0) && (!have_in || in_valid);

  assign in_ready  = !line_start &&
                     ((state == S_INIT) || ((state == S_LOAD) && (left != '0) && have_in));
  assign out_valid = (state == S_OUT);
  assign out_last  = out_valid && (out_cnt == out_len - 1'b1);

  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++)
      sum = sum + SUM_W'($signed({1'b0, taps[t]})) * SUM_W'(cq[t]);
  end

  assign rnd = (sum + RND) >>> CSH;
  assign sat = rnd[SUM_W-1] ? '0 : ((rnd > PMAX) ? PIX_W'(PMAX) : rnd[PIX_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_WAIT;
      acc     <= '0;
      in_cnt  <= '0;
      out_cnt <= '0;
      left    <= '0;
      out_pix <= '0;
      for (int t = 0; t < TAPS; t++) begin
        taps[t] <= '0;
        cq[t]   <= '0;
      end
    end else if (line_start) begin
      state   <= S_INIT;
      acc     <= field_sel ? init_odd : init_even;
      in_cnt  <= '0;
      out_cnt <= '0;
      left    <= '0;
    end else begin
      case (state)
        S_INIT: if (in_valid) begin
          for (int t = 0; t < TAPS; t++) taps[t] <= in_pix;
          in_cnt <= LEN_W'(1);
          left   <= STEP_W'(PRIME);
          state  <= S_LOAD;
        end
        S_LOAD: begin
          if (left == '0) state <= S_PHASE;
          else if (do_shift) begin
            for (int t = 0; t < TAPS - 1; t++) taps[t] <= taps[t+1];
            taps[TAPS-1] <= new_pix;
            if (have_in) in_cnt <= in_cnt + 1'b1;
            left <= left - 1'b1;
          end
        end
        S_PHASE: begin
          for (int t = 0; t < TAPS; t++)
            cq[t] <= $signed(coef[(int'(ph) * TAPS + t) * COEF_W +: COEF_W]);
          state <= S_FIR;
        end
        S_FIR: begin
          out_pix <= sat;
          state   <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          acc     <= acc + ACC_W'(inc);
          left    <= step;
          out_cnt <= out_cnt + 1'b1;
          state   <= out_last ? S_WAIT : S_LOAD;
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  AST_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> in_cnt <= in_len); // R7

  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && !line_start |=> !out_valid && !in_ready); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !line_start |=> out_valid && $stable(out_pix)); // R9

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !out_valid); // R10

endmodule

// File: tb/hresamp_tb_top.sv
`timescale 1ns/1ps
module hresamp_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         line_start = 0, field_sel = 0;
  logic [15:0]  inc = '0;
  logic [23:0]  init_even = '0, init_odd = '0;
  logic [11:0]  in_len = 12'd1, out_len = 12'd1;
  logic [319:0] coef = '0;
  logic         in_valid = 0, in_ready;
  logic [7:0]   in_pix = '0;
  logic         out_valid, out_ready = 0, out_last;
  logic [7:0]   out_pix;

  int n_checks = 0, n_fail = 0;
  int px [256];
  int cf [8][5];
  int L_cur = 1;
  int exp_q [$];

  always #2 clk = ~clk;

  hresamp dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_sel(field_sel),
    .inc(inc), .init_even(init_even), .init_odd(init_odd),
    .in_len(in_len), .out_len(out_len), .coef(coef),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_last(out_last)
  );

  task automatic check(input int act, input int expv, input string req);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int pxg(input int i);
    int j = i;
    if (j < 0) j = 0;
    if (j >= L_cur) j = L_cur - 1;
    return px[j];
  endfunction

  task automatic load_coefs();
    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 5; t++)
        coef[(p*5+t)*8 +: 8] = cf[p][t][7:0];
  endtask

  task automatic build(input int inc_v, input int acc0, input int M, output int cend);
    longint a = acc0;
    int c = 0;
    cend = 0;
    exp_q.delete();
    for (int k = 0; k < M; k++) begin
      int ph = int'((a >> 7) & 7);
      int s = 0;
      int r;
      for (int t = 0; t < 5; t++) s += cf[ph][t] * pxg(c - 2 + t);
      r = (s + 64) >>> 7;
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      exp_q.push_back(r);
      if (k == M - 1) cend = c;
      c += int'(((a + 512 + inc_v) >> 10) - ((a + 512) >> 10));
      a += inc_v;
    end
  endtask

  task automatic run_line(input int inc_v, input bit fld, input int L, input int M,
                          input int rdy_pct, input int vld_pct, input int abort_at,
                          input string tag);
    int cend, idx, k, cyc, want;
    bit pend_stall, fin, fout;
    int stall_pix;
    L_cur = L;
    build(inc_v, fld ? int'(init_odd) : int'(init_even), M, cend);
    inc = inc_v[15:0]; in_len = L[11:0]; out_len = M[11:0]; field_sel = fld;
    in_valid = 0; out_ready = 0; line_start = 1;
    @(negedge clk);
    line_start = 0;
    idx = 0; k = 0; cyc = 0; pend_stall = 0; fin = 0; stall_pix = 0;
    while (k < M && cyc < 20000 && !(abort_at >= 0 && k >= abort_at)) begin
      in_valid  = (idx < L) && ((in_valid && !fin) || ($urandom_range(99) < vld_pct));
      in_pix    = px[(idx < L) ? idx : 0][7:0];
      out_ready = ($urandom_range(99) < rdy_pct);
      #0.5;
      if (pend_stall) check(out_valid ? int'(out_pix) : -1, stall_pix, "R9 stalled output held");
      if (out_valid) check(int'(in_ready), 0, "R9 no input while output pending");
      fin  = in_valid && in_ready;
      fout = out_valid && out_ready;
      pend_stall = out_valid && !out_ready;
      stall_pix  = int'(out_pix);
      if (fout) begin
        check(int'(out_pix), exp_q[k], tag);
        check(int'(out_last), (k == M - 1) ? 1 : 0, "R8 last flag");
        k++;
      end
      if (fin) idx++;
      cyc++;
      @(negedge clk);
    end
    if (abort_at < 0) begin
      want = (cend + 3 < L) ? cend + 3 : L;
      check(k, M, "R8 output count");
      check(int'(out_valid) + int'(in_ready), 0, "R8 idle after line");
      check(idx, want, "R7 input pixels taken");
    end
    in_valid = 0; out_ready = 0;
  endtask

  initial begin
    #(4 * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #0.5;
    check(int'(out_valid), 0, "R1 reset out_valid");
    check(int'(in_ready), 0, "R1 reset in_ready");
    in_valid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #0.5;
      check(int'(in_ready) + int'(out_valid), 0, "R1 idle before line_start");
    end
    in_valid = 0;

    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 5; t++)
        cf[p][t] = int'($urandom_range(140)) - 40;
    load_coefs();
    for (int i = 0; i < 256; i++) px[i] = int'($urandom_range(255));

    run_line(1024, 0, 10, 10, 100, 100, -1, "R2 R5 R6 unity ratio");
    run_line(400,  0, 8,  20, 70,  60,  -1, "R4 upscale reuse");
    run_line(128,  0, 4,  24, 90,  90,  -1, "R5 all phases");
    run_line(2600, 0, 30, 10, 80,  70,  -1, "R4 downscale skip");
    run_line(5000, 0, 50, 8,  100, 50,  -1, "R4 large step");
    init_odd = 24'd700;
    run_line(1024, 1, 12, 10, 90,  90,  -1, "R3 odd field start");
    run_line(1024, 0, 12, 10, 90,  90,  -1, "R3 even field start");
    run_line(700,  0, 1,  6,  100, 100, -1, "R7 single input pixel");
    run_line(1800, 1, 5,  8,  80,  80,  -1, "R7 duplicate past end");
    run_line(900,  0, 16, 14, 25,  70,  -1, "R9 heavy stall");
    run_line(1500, 0, 20, 12, 60,  60,  3,  "R10 aborted line");
    run_line(1300, 0, 20, 12, 60,  60,  -1, "R10 restarted line");

    for (int p = 0; p < 8; p++) begin
      cf[p][0] = -64; cf[p][1] = 40; cf[p][2] = 127; cf[p][3] = 40; cf[p][4] = -64;
    end
    load_coefs();
    for (int i = 0; i < 256; i++) px[i] = ($urandom_range(1) != 0) ? 255 : 0;
    run_line(1024, 0, 24, 24, 100, 100, -1, "R6 saturation");
    run_line(600,  0, 12, 20, 80,  80,  -1, "R6 saturation upscale");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule